// File: doc/BRIEF.md
# Three-Wire Control Register Port

This block is the write-only configuration port of a stereo playback datapath. An external controller sends 16-bit frames over three wires: a data line, a control clock and a latch strobe. The block samples all three with its own system clock through two-flop synchronizers and finds the rising edges of the control clock and the latch. On each control-clock rise it shifts one data bit into a 16-bit register, most significant bit first.

On a latch rise the two low bits of the assembled word pick a destination register and the upper 14 bits are written into it. There are three destinations: a left volume word, a right volume word and a control word. The control word's fields go straight to the datapath. Its serial mode, mute, de-emphasis and interpolation-rate fields are ORed with external pins, so either pins or software can set each feature.

One control bit holds the datapath in reset, which forces a midscale output. Setting it leaves every stored value untouched. The hardware reset input, by contrast, returns all three registers to their defaults.

Top module: `ctl_reg_port`

## Requirements
- R1: Frame bits are taken MSB first, one per rising edge of the control clock as seen after synchronization to the system clock. Each bit is taken from the data level present at that edge.
- R2: The stored registers change only on a latch rising edge. Control clock pulses with no latch edge leave every output unchanged.
- R3: On a latch rise, word bits [1:0] select the destination and bits [15:2] are written to it. 00 selects left volume (`vol_left_o`), 10 selects right volume (`vol_right_o`) and 01 selects the control word.
- R4: A latch rise with address 11 changes no register and no output.
- R5: After hardware reset both volume words equal `VOL_RST` (all ones by default) and the control word is zero. With the pins low this gives `wordlen_o`=24 and zero on every other control output.
- R6: Control word data bit 11 drives `rate_x2_o` and bit 10 drives `rate_x4_o`. Bits 9:8 are the word-length code and bit 7 is the soft reset. Bit 6 is soft mute, bits 5:4 are the serial mode (00 = right-justified) and bits 3:2 are the de-emphasis code (00 none, 01 44.1 kHz).
- R7: `wordlen_o` is 24 for code 00, 20 for 01, 16 for 10 and 24 for 11.
- R8: Soft reset bit = 1 drives `dp_hold_o` high and changes neither volume word. Writing the bit back to 0 releases `dp_hold_o`.
- R9: `mode_o` is the mode field ORed bitwise with `pin_mode_i`, and `mute_o` is soft mute OR `pin_mute_i`. `deemph_o` is the de-emphasis field with `pin_deemph_i` ORed into bit 0. `rate_x2_o` and `rate_x4_o` are ORed with `pin_x2_i` and `pin_x4_i`.
- R10: A latch rise after fewer than 16 new bits commits the shift register as it stands: the older bits sit above the N newest bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Hardware reset, active low |
| ctl_clk_i | input | 1 | Serial control clock |
| ctl_dat_i | input | 1 | Serial control data |
| ctl_lat_i | input | 1 | Latch strobe, rising edge commits |
| pin_mode_i | input | 2 | Serial mode pins |
| pin_mute_i | input | 1 | Mute pin |
| pin_deemph_i | input | 1 | De-emphasis 44.1 kHz pin |
| pin_x2_i | input | 1 | 2x interpolation pin |
| pin_x4_i | input | 1 | 4x interpolation pin |
| vol_left_o | output | FRAME_W-2 | Left volume word |
| vol_right_o | output | FRAME_W-2 | Right volume word |
| rate_x2_o | output | 1 | Effective 2x interpolation mode |
| rate_x4_o | output | 1 | Effective 4x interpolation mode |
| wordlen_o | output | 5 | Right-justified word length in bits |
| dp_hold_o | output | 1 | Datapath soft reset hold |
| mute_o | output | 1 | Effective mute |
| mode_o | output | 2 | Effective serial mode |
| deemph_o | output | 2 | Effective de-emphasis code |

## Verification
The bench uses the defaults: 16-bit frames, two synchronizer stages and all-ones volume reset values. It holds each serial level for four system clocks, so every control clock and latch edge crosses the synchronizers cleanly. With all-ones reset volumes, a write of a zero volume shows up at the outputs. With 16-bit frames, a partial frame that follows a full one produces a word mixing old and new bits, and its expected value can be predicted exactly.

// File: rtl/ctl_reg_port.sv
`timescale 1ns/1ps
module ctl_reg_port #(
  parameter int FRAME_W = 16,
  parameter int SYNC_STAGES = 2,
  parameter logic [FRAME_W-3:0] VOL_RST = '1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctl_clk_i,
  input  logic               ctl_dat_i,
  input  logic               ctl_lat_i,
  input  logic [1:0]         pin_mode_i,
  input  logic               pin_mute_i,
  input  logic               pin_deemph_i,
  input  logic               pin_x2_i,
  input  logic               pin_x4_i,
  output logic [FRAME_W-3:0] vol_left_o,
  output logic [FRAME_W-3:0] vol_right_o,
  output logic               rate_x2_o,
  output logic               rate_x4_o,
  output logic [4:0]         wordlen_o,
  output logic               dp_hold_o,
  output logic               mute_o,
  output logic [1:0]         mode_o,
  output logic [1:0]         deemph_o
);
  localparam int DATA_W = FRAME_W - 2;
  localparam logic [1:0] A_LEFT = 2'b00, A_CTRL = 2'b01, A_RIGHT = 2'b10;

  logic [SYNC_STAGES:0] clk_sy, dat_sy, lat_sy;
  logic [FRAME_W-1:0]   shreg;
  logic [DATA_W-1:0]    vol_l, vol_r, ctl;
  logic                 sclk_rise, lat_rise;
  logic [1:0]           addr;
  logic [DATA_W-1:0]    wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      clk_sy <= '0;
      dat_sy <= '0;
      lat_sy <= '0;
    end else begin
      clk_sy <= {clk_sy[SYNC_STAGES-1:0], ctl_clk_i};
      dat_sy <= {dat_sy[SYNC_STAGES-1:0], ctl_dat_i};
      lat_sy <= {lat_sy[SYNC_STAGES-1:0], ctl_lat_i};
    end

  assign sclk_rise = clk_sy[SYNC_STAGES-1] & ~clk_sy[SYNC_STAGES];
  assign lat_rise  = lat_sy[SYNC_STAGES-1] & ~lat_sy[SYNC_STAGES];
  assign addr      = shreg[1:0];
  assign wdata     = shreg[FRAME_W-1:2];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) shreg <= '0;
    else if (sclk_rise) shreg <= {shreg[FRAME_W-2:0], dat_sy[SYNC_STAGES-1]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      vol_l <= VOL_RST;
      vol_r <= VOL_RST;
      ctl   <= '0;
    end else if (lat_rise) begin
      case (addr)
        A_LEFT:  vol_l <= wdata;
        A_RIGHT: vol_r <= wdata;
        A_CTRL:  ctl   <= wdata;
        default: ;
      endcase
    end

  assign vol_left_o  = vol_l;
  assign vol_right_o = vol_r;
  assign rate_x2_o   = ctl[11] | pin_x2_i;
  assign rate_x4_o   = ctl[10] | pin_x4_i;
  assign dp_hold_o   = ctl[7];
  assign mute_o      = ctl[6] | pin_mute_i;
  assign mode_o      = ctl[5:4] | pin_mode_i;
  assign deemph_o    = ctl[3:2] | {1'b0, pin_deemph_i};

  always_comb
    case (ctl[9:8])
      2'b01:   wordlen_o = 5'd20;
      2'b10:   wordlen_o = 5'd16;
      default: wordlen_o = 5'd24;
    endcase

  always_comb
    AST_WORDLEN_LEGAL: assert (wordlen_o == 5'd16 || wordlen_o == 5'd20 || wordlen_o == 5'd24); // R7

  AST_HOLD_NO_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    !lat_rise |=> $stable(vol_l) && $stable(vol_r) && $stable(ctl)); // R2
  AST_ADDR3_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    lat_rise && addr == 2'b11 |=> $stable(vol_l) && $stable(vol_r) && $stable(ctl)); // R4
  AST_LEFT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    lat_rise && addr == A_LEFT |=> vol_left_o == $past(wdata) && $stable(vol_r)); // R3
  AST_SOFT_RESET_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    lat_rise && addr == A_CTRL |=> dp_hold_o == $past(wdata[7]) && $stable(vol_l)); // R8
  AST_MUTE_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    pin_mute_i |-> mute_o); // R9
endmodule

// File: tb/ctl_reg_port_tb.sv
`timescale 1ns/1ps
module ctl_reg_port_tb;
  logic clk = 0, rst_n = 0;
  logic sclk = 0, sdat = 0, slat = 0;
  logic [1:0] p_mode = 0;
  logic p_mute = 0, p_de = 0, p_x2 = 0, p_x4 = 0;
  logic [13:0] vl, vr;
  logic x2, x4, hold, mute;
  logic [4:0] wl;
  logic [1:0] mode, de;
  int errors = 0, checks = 0;
  bit done = 0;
  logic [13:0] m_l, m_r, m_c;
  logic [15:0] last_sh;

  always #10 clk = ~clk;

  ctl_reg_port u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_clk_i(sclk), .ctl_dat_i(sdat), .ctl_lat_i(slat),
    .pin_mode_i(p_mode), .pin_mute_i(p_mute), .pin_deemph_i(p_de), .pin_x2_i(p_x2),
    .pin_x4_i(p_x4), .vol_left_o(vl), .vol_right_o(vr), .rate_x2_o(x2), .rate_x4_o(x4),
    .wordlen_o(wl), .dp_hold_o(hold), .mute_o(mute), .mode_o(mode), .deemph_o(de));

  localparam int NV = 14;
  localparam logic [15:0] VEC [NV] = '{
    16'hABC0, 16'h5552, 16'h2001, 16'h1001, 16'h0401, 16'h0801, 16'h0C01,
    16'h0101, 16'h00C1, 16'h0021, 16'hFFFF, 16'h0000, 16'hFFFE, 16'h0001};

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(input logic [15:0] w, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk); sdat = w[i]; sclk = 0; wait_clk(4);
      sclk = 1; wait_clk(4);
      last_sh = {last_sh[14:0], w[i]};
    end
    sclk = 0; wait_clk(4);
  endtask

  task automatic latch();
    @(negedge clk); slat = 1; wait_clk(4);
    slat = 0; wait_clk(6);
    case (last_sh[1:0])
      2'b00: m_l = last_sh[15:2];
      2'b10: m_r = last_sh[15:2];
      2'b01: m_c = last_sh[15:2];
      default: ;
    endcase
  endtask

  function automatic logic [4:0] exp_wl(input logic [1:0] c);
    return c == 2'b01 ? 5'd20 : c == 2'b10 ? 5'd16 : 5'd24;
  endfunction

  function automatic logic [13:0] exp_pack(input logic [13:0] c);
    return {c[11] | p_x2, c[10] | p_x4, exp_wl(c[9:8]), c[7], c[6] | p_mute,
            c[5:4] | p_mode, c[3:2] | {1'b0, p_de}};
  endfunction

  function automatic logic [13:0] act_pack();
    return {x2, x4, wl, hold, mute, mode, de};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_all(input string req);
    chk(req, {4'd0, vl, vr}, {4'd0, m_l, m_r});
    chk(req, {18'd0, act_pack()}, {18'd0, exp_pack(m_c)});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    m_l = '1; m_r = '1; m_c = '0; last_sh = '0;
    wait_clk(3); rst_n = 1; wait_clk(2);
    // R5 reset defaults
    chk_all("R5 reset");
    chk("R5 wordlen", {27'd0, wl}, 32'd24);

    // Table walk: R3 decode, R6 fields, R7 word length, R4 address 11
    for (int k = 0; k < NV; k++) begin
      send_bits(VEC[k], 16);
      latch();
      chk_all(VEC[k][1:0] == 2'b11 ? "R4 addr11" : VEC[k][1:0] == 2'b01 ? "R6 R7 ctl" : "R3 vol");
    end

    // R2 continuous clock without latch, then R1 ordering after latch
    send_bits(16'h3F00, 16);
    chk_all("R2 no latch");
    latch();
    chk("R1 msb first", {18'd0, vl}, 32'h0FC0);

    // R8 soft reset keeps volumes
    send_bits(16'h48D0, 16); latch();
    send_bits(16'h0201, 16); latch();
    chk("R8 hold set", {31'd0, hold}, 32'd1);
    chk("R8 vol kept", {4'd0, vl, vr}, {4'd0, 14'h1234, m_r});
    send_bits(16'h0001, 16); latch();
    chk("R8 hold clear", {31'd0, hold}, 32'd0);

    // R9 pin OR
    send_bits(16'h0081, 16); latch();
    @(negedge clk); p_mode = 2'b01; p_mute = 1; p_de = 1; p_x2 = 1; p_x4 = 1; wait_clk(2);
    chk("R9 pins", {18'd0, act_pack()}, {18'd0, exp_pack(m_c)});
    chk("R9 mode", {30'd0, mode}, 32'd3);
    @(negedge clk); p_mode = 0; p_mute = 0; p_de = 0; p_x2 = 0; p_x4 = 0; wait_clk(2);

    // R10 partial frame
    send_bits(16'hA5C3, 16);
    send_bits(16'h0034, 6);
    latch();
    chk("R10 partial", {18'd0, vl}, {18'd0, 14'h1C3D});
    chk_all("R10 all");

    // R5 hardware reset after writes
    send_bits(16'h0F01, 16); latch();
    @(negedge clk); rst_n = 0; wait_clk(3); rst_n = 1; wait_clk(2);
    m_l = '1; m_r = '1; m_c = '0; last_sh = '0;
    chk_all("R5 hw reset");
    finish_run();
  end
endmodule